// File: doc/BRIEF.md
# Windowed Byte Port Unit

This block gives a processor three byte-wide parallel ports through a 16-byte window at the top of the switchable ROM area. An external decoder raises `win_sel` when the address lies in that window and passes the low nibble of the address. The unit answers only while the bank controller's I/O-enable flag is high.

Port A is bidirectional. One direction bit decides whether its low nibble is driven from the port A latch. Its high nibble is always an input. Port B is an output-only byte. Port C is an input-only byte.

A read returns synchronised pin levels on a read bus whose enable stands in for the tri-state drive. A small state machine has three states:
- `ST_IDLE`: waiting for an access.
- `ST_READ`: the read bus is driven.
- `ST_WRITE`: the register update is done and the unit waits for the write strobe to fall.

It has four transitions:
- accept-write (`ST_IDLE`→`ST_WRITE`): the register is updated on this edge.
- accept-read (`ST_IDLE`→`ST_READ`).
- read-release (`ST_READ`→`ST_IDLE`): the read strobe, the window select or the enable is lost.
- write-release (`ST_WRITE`→`ST_IDLE`): the write strobe falls.

Top module: `ioport_unit`

## Requirements
- R1: After reset, `pb_out` is 0x00, `pa_out` is 0x0, `pa_oe` is 0 and `db_oe` is 0.
- R2: An accepted write at offset 0x0 stores the byte in the port A latch, whatever the direction bit. `pa_out` always shows latch bits [3:0].
- R3: An accepted write at offset 0x1 sets `pa_oe` to data bit 0. Pins A[3:0] are driven only while it is 1, and A[7:4] are never driven.
- R4: A read at offset 0x0 returns the levels on all eight port A pins, including any that are driven.
- R5: An accepted write at offset 0x2 sets `pb_out`. A read at offset 0x2 returns the port C pins.
- R6: A read at offset 0x1 or at 0x3–0xF returns 0xFF. A write at 0x3–0xF changes no port.
- R7: With `io_en` or `win_sel` low, no write is accepted and `db_oe` stays 0.
- R8: `db_oe` rises on the first cycle after an edge that samples an enabled read. It falls on the first cycle after an edge that sees the read strobe, the window select or the enable low.
- R9: A write strobe held for several cycles stores only the data present at its first edge.
- R10: If read and write strobes are both sampled high in `ST_IDLE`, the write is performed and the bus is not driven.
- R11: Pin inputs pass two flip-flops. A pin change made before edge k shows on `db_rd` after edge k+1 and not after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_en | input | 1 | I/O-enable flag from the bank controller |
| win_sel | input | 1 | Address lies in the 16-byte port window |
| addr_lo | input | 4 | Address low nibble |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| db_wr | input | 8 | Write data from the CPU |
| db_rd | output | 8 | Read data to the CPU |
| db_oe | output | 1 | Read bus drive enable |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 4 | Port A low-nibble drive value |
| pa_oe | output | 1 | Port A low-nibble drive enable |
| pb_out | output | 8 | Port B output |
| pc_in | input | 8 | Port C pins |

## Verification
A read strobe and a write strobe can arrive in the same sampled cycle. The bench raises both at once on offset 0x2. It judges the outcome in two ways: port B must take the new byte, and `db_oe` must stay low on the following cycle. A read of port A can also coincide with a change of the pins. The bench changes the pins in the middle of a held read and checks that the old value is returned after one edge and the new value after the second.

// File: rtl/ioport_pkg.sv
package ioport_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } port_state_e;

    localparam logic [3:0] OFS_PA_DATA = 4'h0;
    localparam logic [3:0] OFS_PA_DIR  = 4'h1;
    localparam logic [3:0] OFS_PB_PC   = 4'h2;

endpackage

// File: rtl/ioport_sync.sv
module ioport_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_async;
            sync_q <= meta_q;
        end
    end

    assign d_sync = sync_q;
endmodule

// File: rtl/ioport_fsm.sv
module ioport_fsm
    import ioport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic rd,
    input  logic wr,
    output logic wr_fire,
    output logic drive
);
    port_state_e state_q;
    port_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sel && wr)      state_d = ST_WRITE;  // accept-write
                else if (sel && rd) state_d = ST_READ;   // accept-read
            end
            ST_READ: begin
                if (!(sel && rd))   state_d = ST_IDLE;   // read-release
            end
            ST_WRITE: begin
                if (!wr)            state_d = ST_IDLE;   // write-release
            end
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_fire = 1'b0;
        drive   = 1'b0;
        unique case (state_q)
            ST_IDLE:  wr_fire = sel && wr;
            ST_READ:  drive   = 1'b1;
            ST_WRITE: ;
            default:  ;
        endcase
    end
endmodule

// File: rtl/ioport_regs.sv
module ioport_regs
    import ioport_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_fire,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] pa_lat,
    output logic          pa_dir,
    output logic [DW-1:0] pb_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pa_lat <= '0;
            pa_dir <= 1'b0;
            pb_q   <= '0;
        end else if (wr_fire) begin
            unique case (addr)
                AW'(OFS_PA_DATA): pa_lat <= wdata;
                AW'(OFS_PA_DIR):  pa_dir <= wdata[0];
                AW'(OFS_PB_PC):   pb_q   <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ioport_unit.sv
module ioport_unit
    import ioport_pkg::*;
#(
    parameter int DW    = 8,
    parameter int AW    = 4,
    parameter int OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_en,
    input  logic             win_sel,
    input  logic [AW-1:0]    addr_lo,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic [DW-1:0]    db_wr,
    output logic [DW-1:0]    db_rd,
    output logic             db_oe,
    input  logic [DW-1:0]    pa_in,
    output logic [OUT_W-1:0] pa_out,
    output logic             pa_oe,
    output logic [DW-1:0]    pb_out,
    input  logic [DW-1:0]    pc_in
);
    localparam int SYNC_W = 2 * DW;

    logic              sel;
    logic              wr_fire;
    logic              drive;
    logic [DW-1:0]     pa_lat;
    logic              pa_dir;
    logic [DW-1:0]     pb_q;
    logic [SYNC_W-1:0] pins_sync;
    logic [DW-1:0]     pa_s;
    logic [DW-1:0]     pc_s;

    assign sel = io_en && win_sel;

    ioport_sync #(.W(SYNC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({pc_in, pa_in}),
        .d_sync  (pins_sync)
    );

    assign pa_s = pins_sync[DW-1:0];
    assign pc_s = pins_sync[SYNC_W-1:DW];

    ioport_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .rd      (rd_stb),
        .wr      (wr_stb),
        .wr_fire (wr_fire),
        .drive   (drive)
    );

    ioport_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .addr    (addr_lo),
        .wdata   (db_wr),
        .pa_lat  (pa_lat),
        .pa_dir  (pa_dir),
        .pb_q    (pb_q)
    );

    always_comb begin
        db_rd = '1;
        if (drive) begin
            unique case (addr_lo)
                AW'(OFS_PA_DATA): db_rd = pa_s;
                AW'(OFS_PB_PC):   db_rd = pc_s;
                default:          db_rd = '1;
            endcase
        end
    end

    assign db_oe  = drive;
    assign pa_out = pa_lat[OUT_W-1:0];
    assign pa_oe  = pa_dir;
    assign pb_out = pb_q;
endmodule

// File: rtl/ioport_chk.sv
module ioport_chk #(
    parameter int DW    = 8,
    parameter int AW    = 4,
    parameter int OUT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_en,
    input logic             win_sel,
    input logic [AW-1:0]    addr_lo,
    input logic             rd_stb,
    input logic             wr_stb,
    input logic [DW-1:0]    db_rd,
    input logic             db_oe,
    input logic [OUT_W-1:0] pa_out,
    input logic             pa_oe,
    input logic [DW-1:0]    pb_out
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pb_out == '0 && pa_out == '0 && !pa_oe && !db_oe));

    assert_latch_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_out != $past(pa_out)) |-> $past(wr_stb && io_en && win_sel && addr_lo == AW'(0)));

    assert_dir_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_oe != $past(pa_oe)) |-> $past(wr_stb && io_en && win_sel && addr_lo == AW'(1)));

    assert_pb_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_out != $past(pb_out)) |-> $past(wr_stb && io_en && win_sel && addr_lo == AW'(2)));

    assert_unused_ff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (db_oe && addr_lo != AW'(0) && addr_lo != AW'(2)) |-> (db_rd == '1));

    assert_drive_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        db_oe |-> $past(rd_stb && io_en && win_sel));

    assert_drive_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rd_stb) |-> !db_oe);
endmodule

bind ioport_unit ioport_chk #(.DW(DW), .AW(AW), .OUT_W(OUT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .io_en   (io_en),
    .win_sel (win_sel),
    .addr_lo (addr_lo),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb),
    .db_rd   (db_rd),
    .db_oe   (db_oe),
    .pa_out  (pa_out),
    .pa_oe   (pa_oe),
    .pb_out  (pb_out)
);

// File: tb/tb_ioport_unit.sv
module tb_ioport_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_en = 1'b0;
    logic       win_sel = 1'b0;
    logic [3:0] addr_lo = 4'h0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] db_wr = 8'h00;
    logic [7:0] db_rd;
    logic       db_oe;
    logic [7:0] pa_ext = 8'hA5;
    logic [7:0] pa_in;
    logic [3:0] pa_out;
    logic       pa_oe;
    logic [7:0] pb_out;
    logic [7:0] pc_in = 8'h3C;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    assign pa_in = {pa_ext[7:4], pa_oe ? pa_out : pa_ext[3:0]};

    ioport_unit dut (
        .clk(clk), .rst_n(rst_n), .io_en(io_en), .win_sel(win_sel),
        .addr_lo(addr_lo), .rd_stb(rd_stb), .wr_stb(wr_stb), .db_wr(db_wr),
        .db_rd(db_rd), .db_oe(db_oe), .pa_in(pa_in), .pa_out(pa_out),
        .pa_oe(pa_oe), .pb_out(pb_out), .pc_in(pc_in)
    );

    // {is_write, offset, data-or-expected}
    localparam int NV = 11;
    localparam logic [12:0] VEC [NV] = '{
        {1'b1, 4'h2, 8'h5A},
        {1'b0, 4'h2, 8'h3C},
        {1'b0, 4'h0, 8'hA5},
        {1'b1, 4'h0, 8'h36},
        {1'b0, 4'h0, 8'hA5},
        {1'b1, 4'h1, 8'h01},
        {1'b0, 4'h0, 8'hA6},
        {1'b0, 4'h1, 8'hFF},
        {1'b0, 4'h7, 8'hFF},
        {1'b0, 4'hF, 8'hFF},
        {1'b1, 4'h1, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr_lo = a; db_wr = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_rd(input logic [3:0] a, input logic [7:0] exp, input string req);
        repeat (3) @(negedge clk);
        addr_lo = a; rd_stb = 1'b1;
        @(negedge clk);
        check({req, " drive"}, {7'd0, db_oe}, 8'd1);
        check(req, db_rd, exp);
        rd_stb = 1'b0;
        @(negedge clk);
        check("R8 release", {7'd0, db_oe}, 8'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pb", pb_out, 8'h00);
        check("R1 pa_out", {4'd0, pa_out}, 8'h00);
        check("R1 pa_oe", {7'd0, pa_oe}, 8'h00);
        check("R1 db_oe", {7'd0, db_oe}, 8'h00);
        rst_n = 1'b1;
        io_en = 1'b1; win_sel = 1'b1;
        @(negedge clk);

        // table walk: R4 R5 R6 reads, R2 R3 writes
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][12]) do_wr(VEC[i][11:8], VEC[i][7:0]);
            else            do_rd(VEC[i][11:8], VEC[i][7:0], "R4/R5/R6 table read");
        end
        check("R5 pb after write", pb_out, 8'h5A);

        // R2 latch stored while input; R3 direction
        do_wr(4'h0, 8'h39);
        check("R2 latch while input", {4'd0, pa_out}, 8'h09);
        check("R3 dir low", {7'd0, pa_oe}, 8'd0);
        do_wr(4'h1, 8'hFE);
        check("R3 only bit0 counts", {7'd0, pa_oe}, 8'd0);
        do_wr(4'h1, 8'h01);
        check("R3 dir high", {7'd0, pa_oe}, 8'd1);
        check("R2 latch kept", {4'd0, pa_out}, 8'h09);
        do_rd(4'h0, 8'hA9, "R4 driven nibble read");
        do_wr(4'h1, 8'h00);

        // R6 write to unused offsets
        do_wr(4'h3, 8'hFF);
        do_wr(4'hF, 8'h00);
        check("R6 pb untouched", pb_out, 8'h5A);
        check("R6 pa_out untouched", {4'd0, pa_out}, 8'h09);
        check("R6 pa_oe untouched", {7'd0, pa_oe}, 8'd0);

        // R7 disabled unit
        io_en = 1'b0;
        do_wr(4'h2, 8'h11);
        check("R7 write ignored io_en", pb_out, 8'h5A);
        @(negedge clk); addr_lo = 4'h2; rd_stb = 1'b1;
        @(negedge clk);
        check("R7 no drive io_en", {7'd0, db_oe}, 8'd0);
        rd_stb = 1'b0; io_en = 1'b1; win_sel = 1'b0;
        do_wr(4'h2, 8'h22);
        check("R7 write ignored win_sel", pb_out, 8'h5A);
        win_sel = 1'b1;

        // R8 enable lost during a read
        @(negedge clk); addr_lo = 4'h2; rd_stb = 1'b1;
        @(negedge clk);
        check("R8 drive on", {7'd0, db_oe}, 8'd1);
        io_en = 1'b0;
        @(negedge clk);
        check("R8 drive off on enable loss", {7'd0, db_oe}, 8'd0);
        rd_stb = 1'b0; io_en = 1'b1;

        // R9 held write stores first data only
        @(negedge clk); addr_lo = 4'h2; db_wr = 8'h77; wr_stb = 1'b1;
        @(negedge clk); db_wr = 8'h88;
        repeat (2) @(negedge clk);
        wr_stb = 1'b0;
        @(negedge clk);
        check("R9 single store", pb_out, 8'h77);

        // R10 read and write together
        @(negedge clk); addr_lo = 4'h2; db_wr = 8'h44; wr_stb = 1'b1; rd_stb = 1'b1;
        @(negedge clk);
        check("R10 write wins", pb_out, 8'h44);
        check("R10 no drive", {7'd0, db_oe}, 8'd0);
        wr_stb = 1'b0; rd_stb = 1'b0;
        @(negedge clk);

        // R11 two-stage latency during a held read
        repeat (3) @(negedge clk);
        addr_lo = 4'h0; rd_stb = 1'b1;
        @(negedge clk);
        pa_ext = 8'h5C;
        @(negedge clk);
        check("R11 old after one edge", db_rd, 8'hA5);
        @(negedge clk);
        check("R11 new after two edges", db_rd, 8'h5C);
        rd_stb = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule